// File: doc/BRIEF.md
# Masked Cross-Lane Row Permute Unit

This block serves a 64-lane SIMD register file. In one operation it gives every lane a source operand taken from another lane of the same vector. It then combines that operand with the lane's current destination value, using a selectable integer operation. Only the lanes allowed by three masks are written: the row mask, the bank mask and the execution mask. The block uses these groupings:

- a row is 16 consecutive lanes;
- a bank is 4 consecutive lanes inside a row.

Three lane-movement patterns are available:

- a right shift inside each row by a programmable distance;
- a broadcast of each row's top lane into the row above;
- a broadcast of lane 31 into the two upper rows.

When a lane's computed source lies outside the range that the pattern allows, a boundary bit decides what happens:

- with the bit clear, the lane keeps its old destination;
- with the bit set, the lane reads zero and is still combined with its old destination.

A caller presents the source vector, the old destination vector, the controls and the masks, all in the same cycle as a one-cycle `start` strobe. The full result vector is registered. It appears together with `res_valid` one cycle later. Lanes that are not written carry their old destination value into the result.

Top module: `rowperm_unit`

## Requirements
- R1: Mode code 0 (`perm_mode`=0) with a nonzero `shift_amt` N: a lane at position p inside its row (p = lane mod 16) uses the source of lane (lane − N), provided p ≥ N.
- R2: In mode 0, a lane with p < N has an out-of-range source. When `bound_zero`=0, such a lane is not written, and its result equals its old destination.
- R3: When `bound_zero`=1, an out-of-range source reads as zero. The lane is written with op(0, old), subject to the masks.
- R4: Mode code 1: every lane of row r ≥ 1 (r = lane / 16) uses the source of lane 16·r − 1. Row 0 is out of range.
- R5: Mode code 2: every lane of rows 2 and 3 uses the source of lane 31. Rows 0 and 1 are out of range.
- R6: `op_sel` picks the operation, with s the permuted source and d the old destination:
  - 0: s + d, modulo 2^32;
  - 1: the signed minimum of s and d;
  - 2: the signed maximum of s and d;
  - 3: s alone.
- R7: A lane is left unwritten, and its result equals its old destination, in either case:
  - bit (lane / 16) of `row_mask` is 0;
  - bit ((lane mod 16) / 4) of `bank_mask` is 0.
- R8: A lane whose `exec_mask` bit is 0 is never written. Its result equals its old destination.
- R9: Mode 0 with `shift_amt`=0, and mode code 3, make every lane use its own source, and that source is always in range.
- R10: Reset clears `res_vec` and `res_valid`. `start` in a cycle gives `res_valid`=1 in the next cycle, and `res_valid`=0 otherwise. `res_vec` changes only in the cycle after a `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Strobe: capture the operation this cycle |
| perm_mode | input | 2 | 0 row shift, 1 row-carry broadcast, 2 lane-31 broadcast, 3 identity |
| shift_amt | input | 4 | Shift distance for mode 0 |
| bound_zero | input | 1 | 1: out-of-range sources read zero; 0: those lanes keep their old value |
| op_sel | input | 2 | 0 add, 1 signed min, 2 signed max, 3 move |
| row_mask | input | 4 | One enable bit per 16-lane row |
| bank_mask | input | 4 | One enable bit per 4-lane bank, the same for every row |
| exec_mask | input | 64 | One enable bit per lane |
| src_vec | input | 2048 | Source vector, lane k in bits [32k+31:32k] |
| old_vec | input | 2048 | Old destination vector, same packing as the source |
| res_vec | output | 2048 | Registered result vector |
| res_valid | output | 1 | High in the cycle after `start` |

## Verification
A wrong source index or a wrong validity decision shows up in the result of the very next cycle. It appears as a lane value that matches neither the expected combination nor the old destination. Such errors are most exposed at row edges, where the shifted source crosses p = N.

A fault in mask decoding makes whole rows or aligned groups of four lanes either take a new value or keep their old one, against expectation. Each result is checked lane by lane against a model that is computed independently, so a fault in any single lane is caught in the cycle it is produced.

Valid-flag or hold faults show up as `res_valid` or `res_vec` changing in a cycle with no preceding `start`.

// File: rtl/rowperm_pkg.sv
`timescale 1ns/1ps
package rowperm_pkg;

  typedef enum logic [1:0] {
    PM_ROW_SHR  = 2'd0,
    PM_ROW_CARRY = 2'd1,
    PM_HALF_BCAST = 2'd2,
    PM_IDENTITY = 2'd3
  } perm_mode_e;

  typedef enum logic [1:0] {
    LOP_ADD  = 2'd0,
    LOP_SMIN = 2'd1,
    LOP_SMAX = 2'd2,
    LOP_MOVE = 2'd3
  } lane_op_e;

endpackage

// File: rtl/rowperm_route.sv
`timescale 1ns/1ps
module rowperm_route
  import rowperm_pkg::*;
#(
  parameter int LANES     = 64,
  parameter int ROW_LANES = 16,
  parameter int DW        = 32,
  localparam int LW = $clog2(LANES),
  localparam int AW = $clog2(ROW_LANES)
) (
  input  logic [1:0]          mode,
  input  logic [AW-1:0]       amt,
  input  logic [LANES*DW-1:0] src_vec,
  output logic [LANES*DW-1:0] perm_vec,
  output logic [LANES-1:0]    src_ok
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int ROW = g / ROW_LANES;
    localparam int POS = g % ROW_LANES;

    logic [LW-1:0] idx;
    logic          ok;

    always_comb begin
      idx = LW'(g);
      ok  = 1'b0;
      unique case (perm_mode_e'(mode))
        PM_ROW_SHR: begin
          if (amt == '0) begin
            ok = 1'b1;
          end else if (POS >= int'(amt)) begin
            idx = LW'(g - int'(amt));
            ok  = 1'b1;
          end
        end
        PM_ROW_CARRY: begin
          if (ROW > 0) begin
            idx = LW'(ROW * ROW_LANES - 1);
            ok  = 1'b1;
          end
        end
        PM_HALF_BCAST: begin
          if (ROW >= 2) begin
            idx = LW'(2 * ROW_LANES - 1);
            ok  = 1'b1;
          end
        end
        default: begin
          ok = 1'b1;
        end
      endcase
    end

    assign src_ok[g] = ok;
    assign perm_vec[g*DW +: DW] = ok ? src_vec[int'(idx)*DW +: DW] : '0;
  end

endmodule

// File: rtl/rowperm_gate.sv
`timescale 1ns/1ps
module rowperm_gate #(
  parameter int LANES      = 64,
  parameter int ROW_LANES  = 16,
  parameter int BANK_LANES = 4,
  localparam int ROWS  = LANES / ROW_LANES,
  localparam int BANKS = ROW_LANES / BANK_LANES
) (
  input  logic [LANES-1:0] exec_mask,
  input  logic [ROWS-1:0]  row_mask,
  input  logic [BANKS-1:0] bank_mask,
  input  logic [LANES-1:0] src_ok,
  input  logic             bound_zero,
  output logic [LANES-1:0] lane_we
);

  for (genvar g = 0; g < LANES; g++) begin : g_we
    localparam int ROW  = g / ROW_LANES;
    localparam int BANK = (g % ROW_LANES) / BANK_LANES;
    assign lane_we[g] = exec_mask[g] & row_mask[ROW] & bank_mask[BANK]
                      & (src_ok[g] | bound_zero);
  end

endmodule

// File: rtl/rowperm_alu.sv
`timescale 1ns/1ps
module rowperm_alu
  import rowperm_pkg::*;
#(
  parameter int LANES = 64,
  parameter int DW    = 32
) (
  input  logic [1:0]          op_sel,
  input  logic [LANES*DW-1:0] perm_vec,
  input  logic [LANES*DW-1:0] old_vec,
  output logic [LANES*DW-1:0] alu_vec
);

  function automatic logic [DW-1:0] lane_op(input logic [1:0] sel,
                                            input logic [DW-1:0] s,
                                            input logic [DW-1:0] d);
    logic [DW-1:0] r;
    unique case (lane_op_e'(sel))
      LOP_ADD:  r = s + d;
      LOP_SMIN: r = ($signed(s) < $signed(d)) ? s : d;
      LOP_SMAX: r = ($signed(s) > $signed(d)) ? s : d;
      default:  r = s;
    endcase
    return r;
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : g_op
    assign alu_vec[g*DW +: DW] = lane_op(op_sel, perm_vec[g*DW +: DW], old_vec[g*DW +: DW]);
  end

endmodule

// File: rtl/rowperm_unit.sv
`timescale 1ns/1ps
module rowperm_unit #(
  parameter int LANES      = 64,
  parameter int ROW_LANES  = 16,
  parameter int BANK_LANES = 4,
  parameter int DW         = 32,
  localparam int ROWS  = LANES / ROW_LANES,
  localparam int BANKS = ROW_LANES / BANK_LANES,
  localparam int AW    = $clog2(ROW_LANES),
  localparam int VW    = LANES * DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [1:0]       perm_mode,
  input  logic [AW-1:0]    shift_amt,
  input  logic             bound_zero,
  input  logic [1:0]       op_sel,
  input  logic [ROWS-1:0]  row_mask,
  input  logic [BANKS-1:0] bank_mask,
  input  logic [LANES-1:0] exec_mask,
  input  logic [VW-1:0]    src_vec,
  input  logic [VW-1:0]    old_vec,
  output logic [VW-1:0]    res_vec,
  output logic             res_valid
);

  logic [VW-1:0]    perm_vec;
  logic [VW-1:0]    alu_vec;
  logic [VW-1:0]    next_vec;
  logic [LANES-1:0] src_ok;
  logic [LANES-1:0] lane_we;

  rowperm_route #(.LANES(LANES), .ROW_LANES(ROW_LANES), .DW(DW)) u_route (
    .mode     (perm_mode),
    .amt      (shift_amt),
    .src_vec  (src_vec),
    .perm_vec (perm_vec),
    .src_ok   (src_ok)
  );

  rowperm_gate #(.LANES(LANES), .ROW_LANES(ROW_LANES), .BANK_LANES(BANK_LANES)) u_gate (
    .exec_mask  (exec_mask),
    .row_mask   (row_mask),
    .bank_mask  (bank_mask),
    .src_ok     (src_ok),
    .bound_zero (bound_zero),
    .lane_we    (lane_we)
  );

  rowperm_alu #(.LANES(LANES), .DW(DW)) u_alu (
    .op_sel   (op_sel),
    .perm_vec (perm_vec),
    .old_vec  (old_vec),
    .alu_vec  (alu_vec)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_sel
    assign next_vec[g*DW +: DW] = lane_we[g] ? alu_vec[g*DW +: DW] : old_vec[g*DW +: DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_vec   <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= start;
      if (start) res_vec <= next_vec;
    end
  end

  // R10
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> res_valid);
  // R10
  valid_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !res_valid);
  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(res_vec));

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    // R8
    exec_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !exec_mask[g]) |=> (res_vec[g*DW +: DW] == $past(old_vec[g*DW +: DW])));
    // R2
    oob_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !bound_zero && !src_ok[g]) |=> (res_vec[g*DW +: DW] == $past(old_vec[g*DW +: DW])));
    // R7
    mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !(row_mask[g / ROW_LANES] && bank_mask[(g % ROW_LANES) / BANK_LANES]))
      |=> (res_vec[g*DW +: DW] == $past(old_vec[g*DW +: DW])));
  end

endmodule

// File: tb/rowperm_unit_tb.sv
`timescale 1ns/1ps
module rowperm_unit_tb;
  localparam int L = 64;
  localparam int R = 16;
  localparam int D = 32;
  localparam int V = L * D;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   perm_mode = '0;
  logic [3:0]   shift_amt = '0;
  logic         bound_zero = 1'b0;
  logic [1:0]   op_sel = '0;
  logic [3:0]   row_mask = '0;
  logic [3:0]   bank_mask = '0;
  logic [L-1:0] exec_mask = '0;
  logic [V-1:0] src_vec = '0;
  logic [V-1:0] old_vec = '0;
  logic [V-1:0] res_vec;
  logic         res_valid;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  logic [V-1:0] exp_q[$];
  string        tag_q[$];
  logic [V-1:0] last_exp = '0;

  always #2.5 clk = ~clk;

  rowperm_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .perm_mode(perm_mode),
    .shift_amt(shift_amt), .bound_zero(bound_zero), .op_sel(op_sel),
    .row_mask(row_mask), .bank_mask(bank_mask), .exec_mask(exec_mask),
    .src_vec(src_vec), .old_vec(old_vec), .res_vec(res_vec), .res_valid(res_valid)
  );

  function automatic logic [V-1:0] rand_vec();
    logic [V-1:0] v;
    for (int k = 0; k < L; k++) v[k*D +: D] = $urandom;
    return v;
  endfunction

  // Monitor: pops one expected vector per valid result
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      compared++;
      if (exp_q.size() == 0) begin
        mismatched++;
        $display("FAIL R10: unexpected res_valid, got 1 expected 0");
      end else begin
        logic [V-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        last_exp = e;
        if (res_vec !== e) begin
          mismatched++;
          for (int k = 0; k < L; k++)
            if (res_vec[k*D +: D] !== e[k*D +: D]) begin
              $display("FAIL %s: lane %0d got %h expected %h", t, k, res_vec[k*D +: D], e[k*D +: D]);
              break;
            end
        end
      end
    end
  end

  task automatic drive(input string tag, input logic [1:0] md, input logic [3:0] amt,
                       input logic bz, input logic [1:0] op, input logic [3:0] rm,
                       input logic [3:0] bm, input logic [L-1:0] ex);
    logic [V-1:0] s, o, e;
    s = rand_vec();
    o = rand_vec();
    for (int k = 0; k < L; k++) begin
      int rw, ps, ix;
      bit ok, we;
      logic [D-1:0] a, b, r;
      rw = k / R; ps = k % R; ix = k; ok = 0;
      if (md == 2'd0) begin
        if (amt == 0) ok = 1;                       // R9
        else if (ps >= int'(amt)) begin ok = 1; ix = k - int'(amt); end  // R1
      end else if (md == 2'd1) begin
        if (rw >= 1) begin ok = 1; ix = rw * R - 1; end   // R4
      end else if (md == 2'd2) begin
        if (rw >= 2) begin ok = 1; ix = 31; end           // R5
      end else ok = 1;                                     // R9
      a = ok ? s[ix*D +: D] : '0;                          // R3
      b = o[k*D +: D];
      case (op)                                            // R6
        2'd0: r = a + b;
        2'd1: r = ($signed(a) < $signed(b)) ? a : b;
        2'd2: r = ($signed(a) > $signed(b)) ? a : b;
        default: r = a;
      endcase
      we = ex[k] && rm[rw] && bm[ps / 4] && (ok || bz);    // R2 R7 R8
      e[k*D +: D] = we ? r : b;
    end
    perm_mode = md; shift_amt = amt; bound_zero = bz; op_sel = op;
    row_mask = rm; bank_mask = bm; exec_mask = ex;
    src_vec = s; old_vec = o; start = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle_check();
    start = 1'b0;
    src_vec = rand_vec();
    old_vec = rand_vec();
    @(negedge clk);
    compared++;
    if (res_valid !== 1'b0) begin
      mismatched++;
      $display("FAIL R10: res_valid got %b expected 0", res_valid);
    end
    compared++;
    if (res_vec !== last_exp) begin
      mismatched++;
      $display("FAIL R10: res_vec not held, got %h expected %h", res_vec[D-1:0], last_exp[D-1:0]);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      mismatched++;
      $display("FAIL R10: watchdog expired, got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compared++;
    if (res_valid !== 1'b0 || res_vec !== '0) begin
      mismatched++;
      $display("FAIL R10: reset state got %b/%h expected 0/0", res_valid, res_vec[D-1:0]);
    end
    rst_n = 1'b1;
    @(negedge clk);

    drive("R1", 2'd0, 4'd1, 1'b0, 2'd0, 4'hF, 4'hF, '1);  idle_check();
    drive("R2", 2'd0, 4'd15, 1'b0, 2'd1, 4'hF, 4'hF, '1); idle_check();
    drive("R3", 2'd0, 4'd4, 1'b1, 2'd2, 4'hF, 4'hF, '1);  idle_check();
    drive("R3", 2'd1, 4'd0, 1'b1, 2'd0, 4'hF, 4'hF, '1);  idle_check();
    drive("R4", 2'd1, 4'd7, 1'b0, 2'd0, 4'hF, 4'hF, '1);  idle_check();
    drive("R5", 2'd2, 4'd0, 1'b0, 2'd2, 4'hF, 4'hF, '1);  idle_check();
    drive("R6", 2'd0, 4'd8, 1'b0, 2'd3, 4'hF, 4'hF, '1);  idle_check();
    drive("R6", 2'd0, 4'd2, 1'b0, 2'd1, 4'hF, 4'hF, '1);  idle_check();
    drive("R7", 2'd0, 4'd3, 1'b0, 2'd0, 4'b0101, 4'hF, '1);  idle_check();
    drive("R7", 2'd1, 4'd0, 1'b1, 2'd2, 4'hF, 4'b1010, '1);  idle_check();
    drive("R8", 2'd0, 4'd5, 1'b1, 2'd0, 4'hF, 4'hF, {$urandom, $urandom}); idle_check();
    drive("R9", 2'd0, 4'd0, 1'b0, 2'd0, 4'hF, 4'hF, '1);  idle_check();
    drive("R9", 2'd3, 4'd9, 1'b0, 2'd2, 4'hF, 4'hF, '1);  idle_check();
    // R10: back-to-back starts
    drive("R10", 2'd0, 4'd6, 1'b0, 2'd0, 4'hF, 4'hF, '1);
    drive("R10", 2'd2, 4'd0, 1'b1, 2'd1, 4'b0110, 4'b0111, '1);
    drive("R10", 2'd1, 4'd0, 1'b0, 2'd3, 4'hF, 4'hF, {$urandom, $urandom});
    idle_check();
    for (int n = 0; n < 20; n++) begin
      drive("R6", 2'($urandom), 4'($urandom), 1'($urandom), 2'($urandom),
            4'($urandom), 4'($urandom), {$urandom, $urandom});
    end
    idle_check();

    if (exp_q.size() != 0) begin
      mismatched++;
      $display("FAIL R10: %0d results missing, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule